// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Responder

This block sits on the processor bus on the system side and serves interrupt acknowledge transactions for an interrupt controller. The controller reports that it has an interrupt pending and gives its 8-bit vector. The responder raises the interrupt request line toward the processor and keeps it raised until the acknowledge really begins. It does this because the processor decides internally on which instruction boundary it takes the request, and the system side cannot see that boundary.

The processor acknowledges with two locked reads. Both reads have the data/control, memory/IO and write/read qualifiers low and address bits 31..3 at zero. The two reads differ only in their byte enables. The responder decodes each read and returns a one-clock ready. On the second read only, it drives the vector latched at the first read onto data bits 7..0. When the pair completes, it pulses an acknowledged signal to the controller. Any number of idle clocks may come between the two reads. If the lock is released between them, the pair tracker drops back to waiting for a first read.

Top module: `inta_responder`

## Requirements
- R1: While no acknowledge pair is in progress, `intr_req` equals `irq_pending` as sampled at the previous rising clock edge. All outputs are low after reset.
- R2: A first read is a clock in which `ads`, `lock` and `byte_en == 8'hEF` are all high or true, `cyc_dc`, `cyc_mio` and `cyc_wr` are all 0, and `addr[31:3]` is zero, while the tracker is idle. The responder answers it with `rdy` high for exactly the following clock, with `data_oe` low.
- R3: `intr_req` is low from the clock that follows the detection of a first read until the pair completes or is aborted, even if `irq_pending` stays high.
- R4: A second read has the same encoding with `byte_en == 8'hFE` and arrives while the tracker awaits it. The responder answers it with `rdy` and `data_oe` high for exactly the following clock, with `data_out[7:0]` equal to the vector and `data_out[63:8]` zero.
- R5: The second read is accepted after any number of idle clocks (zero or more) that follow the first ready.
- R6: The vector is captured from `irq_vector` when the first read is detected. Later changes on `irq_vector` do not change the value returned on the second read.
- R7: `ack_pulse` is high for exactly one clock, the clock right after the second read's ready clock.
- R8: If `lock` is low at a clock edge while the tracker awaits the second read, the pair is abandoned. A later read with `byte_en == 8'hFE` gets no ready and no `ack_pulse`, and `intr_req` again follows `irq_pending`.
- R9: A cycle with `ads` high gets no ready and leaves the tracker unchanged when any of the following holds: a qualifier is nonzero, any address bit 31..3 is set, the byte enables match neither pattern, the pattern is the second one while idle, or `lock` is low.
- R10: `data_oe` is high only together with `rdy`, and `data_out` is all zero whenever `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| ads | input | 1 | Address strobe, high for the first clock of a bus cycle |
| cyc_dc | input | 1 | Data/control cycle qualifier |
| cyc_mio | input | 1 | Memory/IO cycle qualifier |
| cyc_wr | input | 1 | Write/read cycle qualifier |
| byte_en | input | 8 | Byte enables of the cycle, active high as encoded |
| addr | input | 32 | Cycle address |
| lock | input | 1 | High while the processor holds a locked sequence |
| irq_pending | input | 1 | Controller has an interrupt to deliver |
| irq_vector | input | 8 | Vector offered by the controller |
| intr_req | output | 1 | Interrupt request toward the processor |
| rdy | output | 1 | Ready for an acknowledge read |
| data_out | output | 64 | Read data toward the processor |
| data_oe | output | 1 | Data bus drive enable |
| ack_pulse | output | 1 | One-clock notice that the acknowledge completed |

## Verification
A tracker stuck in a wrong state shows at the ports within one or two clocks. It either misses a ready, so the processor would stall on the bus, or it gives a second-read ready with the vector to a read that should be ignored. A stale or overwritten vector latch shows only on the second read's ready clock. So every vector value is swept with `irq_vector` changed during the gap. The bench also sweeps all byte-enable patterns, qualifier combinations and address bits against the decoder, and aborts the pair by dropping the lock. These runs check that `intr_req` is masked during the pair and returns on the next clock after completion or abort.

// File: rtl/inta_pkg.sv
package inta_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_FIRST_RDY  = 2'd1,
    ST_WAIT2      = 2'd2,
    ST_SECOND_RDY = 2'd3
  } ack_state_t;

  localparam logic [7:0] BE_FIRST_DEF  = 8'hEF;
  localparam logic [7:0] BE_SECOND_DEF = 8'hFE;
endpackage

// File: rtl/inta_decode.sv
module inta_decode #(
  parameter int ADDR_W = 32,
  parameter int ADDR_LO = 3,
  parameter int BE_W = 8,
  parameter logic [BE_W-1:0] BE_FIRST = 8'hEF,
  parameter logic [BE_W-1:0] BE_SECOND = 8'hFE
) (
  input  logic              ads,
  input  logic              cyc_dc,
  input  logic              cyc_mio,
  input  logic              cyc_wr,
  input  logic [BE_W-1:0]   byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  output logic              hit_first,
  output logic              hit_second
);
  localparam int HI_W = ADDR_W - ADDR_LO;

  logic type_ok;
  logic addr_ok;
  logic base_ok;

  always_comb begin
    type_ok    = !cyc_dc && !cyc_mio && !cyc_wr;
    addr_ok    = (addr[ADDR_W-1:ADDR_LO] == {HI_W{1'b0}});
    base_ok    = ads && lock && type_ok && addr_ok;
    hit_first  = base_ok && (byte_en == BE_FIRST);
    hit_second = base_ok && (byte_en == BE_SECOND);
  end
endmodule

// File: rtl/inta_tracker.sv
module inta_tracker
  import inta_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       lock,
  input  logic       hit_first,
  input  logic       hit_second,
  output ack_state_t state,
  output ack_state_t state_nx
);
  always_comb begin
    state_nx = state;
    unique case (state)
      ST_IDLE:       if (hit_first) state_nx = ST_FIRST_RDY;
      ST_FIRST_RDY:  state_nx = ST_WAIT2;
      ST_WAIT2: begin
        if (!lock)           state_nx = ST_IDLE;
        else if (hit_second) state_nx = ST_SECOND_RDY;
      end
      ST_SECOND_RDY: state_nx = ST_IDLE;
      default:       state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end
endmodule

// File: rtl/inta_drive.sv
module inta_drive
  import inta_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int VEC_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ack_state_t        state,
  input  ack_state_t        state_nx,
  input  logic              irq_pending,
  input  logic [VEC_W-1:0]  irq_vector,
  output logic              intr_req,
  output logic              rdy,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ack_pulse
);
  localparam int PAD_W = DATA_W - VEC_W;

  logic [VEC_W-1:0] vec_q;
  logic             take_vec;
  logic             oe_d;

  always_comb begin
    take_vec = (state == ST_IDLE) && (state_nx == ST_FIRST_RDY);
    oe_d     = (state_nx == ST_SECOND_RDY) && (state == ST_WAIT2);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_q     <= '0;
      intr_req  <= 1'b0;
      rdy       <= 1'b0;
      data_oe   <= 1'b0;
      data_out  <= '0;
      ack_pulse <= 1'b0;
    end else begin
      if (take_vec) vec_q <= irq_vector;
      intr_req  <= irq_pending && (state_nx == ST_IDLE);
      rdy       <= take_vec || oe_d;
      data_oe   <= oe_d;
      data_out  <= oe_d ? {{PAD_W{1'b0}}, vec_q} : '0;
      ack_pulse <= (state == ST_SECOND_RDY);
    end
  end
endmodule

// File: rtl/inta_responder.sv
module inta_responder
  import inta_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int ADDR_LO = 3,
  parameter int BE_W = 8,
  parameter int DATA_W = 64,
  parameter int VEC_W = 8,
  parameter logic [BE_W-1:0] BE_FIRST = BE_FIRST_DEF,
  parameter logic [BE_W-1:0] BE_SECOND = BE_SECOND_DEF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads,
  input  logic              cyc_dc,
  input  logic              cyc_mio,
  input  logic              cyc_wr,
  input  logic [BE_W-1:0]   byte_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              lock,
  input  logic              irq_pending,
  input  logic [VEC_W-1:0]  irq_vector,
  output logic              intr_req,
  output logic              rdy,
  output logic [DATA_W-1:0] data_out,
  output logic              data_oe,
  output logic              ack_pulse
);
  logic       hit_first;
  logic       hit_second;
  ack_state_t state;
  ack_state_t state_nx;

  inta_decode #(
    .ADDR_W(ADDR_W), .ADDR_LO(ADDR_LO), .BE_W(BE_W),
    .BE_FIRST(BE_FIRST), .BE_SECOND(BE_SECOND)
  ) u_dec (
    .ads(ads), .cyc_dc(cyc_dc), .cyc_mio(cyc_mio), .cyc_wr(cyc_wr),
    .byte_en(byte_en), .addr(addr), .lock(lock),
    .hit_first(hit_first), .hit_second(hit_second)
  );

  inta_tracker u_trk (
    .clk(clk), .rst(rst), .lock(lock),
    .hit_first(hit_first), .hit_second(hit_second),
    .state(state), .state_nx(state_nx)
  );

  inta_drive #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_drv (
    .clk(clk), .rst(rst), .state(state), .state_nx(state_nx),
    .irq_pending(irq_pending), .irq_vector(irq_vector),
    .intr_req(intr_req), .rdy(rdy), .data_out(data_out),
    .data_oe(data_oe), .ack_pulse(ack_pulse)
  );
endmodule

// File: rtl/inta_checker.sv
module inta_checker #(
  parameter int DATA_W = 64,
  parameter int VEC_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              intr_req,
  input logic              rdy,
  input logic [DATA_W-1:0] data_out,
  input logic              data_oe,
  input logic              ack_pulse
);
  // R2
  rdy_single_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |=> !rdy);
  // R10
  oe_with_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> rdy);
  // R10
  data_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !data_oe |-> (data_out == '0));
  // R4
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |-> (data_out[DATA_W-1:VEC_W] == '0));
  // R3
  intr_masked_chk: assert property (@(posedge clk) disable iff (rst)
    rdy |-> !intr_req);
  // R7
  ack_after_oe_chk: assert property (@(posedge clk) disable iff (rst)
    data_oe |=> ack_pulse);
  // R7
  ack_single_chk: assert property (@(posedge clk) disable iff (rst)
    ack_pulse |=> !ack_pulse);
endmodule

bind inta_responder inta_checker #(.DATA_W(DATA_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst(rst), .intr_req(intr_req), .rdy(rdy),
  .data_out(data_out), .data_oe(data_oe), .ack_pulse(ack_pulse)
);

// File: tb/tb_inta_responder.sv
module tb_inta_responder;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ads = 1'b0;
  logic        cyc_dc = 1'b0, cyc_mio = 1'b0, cyc_wr = 1'b0;
  logic [7:0]  byte_en = 8'hFF;
  logic [31:0] addr = '0;
  logic        lock = 1'b0;
  logic        irq_pending = 1'b0;
  logic [7:0]  irq_vector = '0;
  logic        intr_req, rdy, data_oe, ack_pulse;
  logic [63:0] data_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  inta_responder dut (
    .clk(clk), .rst(rst), .ads(ads), .cyc_dc(cyc_dc), .cyc_mio(cyc_mio),
    .cyc_wr(cyc_wr), .byte_en(byte_en), .addr(addr), .lock(lock),
    .irq_pending(irq_pending), .irq_vector(irq_vector),
    .intr_req(intr_req), .rdy(rdy), .data_out(data_out),
    .data_oe(data_oe), .ack_pulse(ack_pulse)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Drives one cycle; samples the ready clock and the clock after it.
  task automatic issue(input logic [2:0] typ, input logic [7:0] be, input logic [31:0] a,
                       input logic lk, output logic r, output logic o,
                       output logic [63:0] d, output logic it,
                       output logic r2, output logic ak);
    @(negedge clk);
    ads = 1'b1; {cyc_dc, cyc_mio, cyc_wr} = typ; byte_en = be; addr = a; lock = lk;
    @(negedge clk);
    ads = 1'b0; {cyc_dc, cyc_mio, cyc_wr} = 3'b000; byte_en = 8'hFF; addr = '0;
    r = rdy; o = data_oe; d = data_out; it = intr_req;
    @(negedge clk);
    r2 = rdy; ak = ack_pulse;
  endtask

  task automatic abort_pair();
    @(negedge clk); lock = 1'b0;
    @(negedge clk);
    check("R8 rdy after lock drop", {63'd0, rdy}, 64'd0);
    lock = 1'b1;
  endtask

  initial begin
    logic r, o, it, r2, ak;
    logic [63:0] d;
    repeat (3) @(negedge clk);
    check("R1 reset intr", {63'd0, intr_req}, 64'd0);
    check("R1 reset rdy", {63'd0, rdy}, 64'd0);
    check("R10 reset oe", {63'd0, data_oe}, 64'd0);
    check("R10 reset data", data_out, 64'd0);
    check("R7 reset ack", {63'd0, ack_pulse}, 64'd0);
    rst = 1'b0;

    // R1: request follows pending
    irq_pending = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 intr high", {63'd0, intr_req}, 64'd1);
    irq_pending = 1'b0;
    @(negedge clk);
    check("R1 intr low", {63'd0, intr_req}, 64'd0);
    irq_pending = 1'b1;
    lock = 1'b1;

    // R9: nonzero qualifiers
    for (int t = 1; t < 8; t++) begin
      issue(t[2:0], 8'hEF, 32'd0, 1'b1, r, o, d, it, r2, ak);
      check("R9 qualifier", {63'd0, r}, 64'd0);
    end
    // R9: any high address bit
    for (int b = 3; b < 32; b++) begin
      issue(3'b000, 8'hEF, 32'd1 << b, 1'b1, r, o, d, it, r2, ak);
      check("R9 address", {63'd0, r}, 64'd0);
    end
    // R9: lock low on first read
    issue(3'b000, 8'hEF, 32'd0, 1'b0, r, o, d, it, r2, ak);
    check("R9 unlocked", {63'd0, r}, 64'd0);
    lock = 1'b1;

    // R2/R9: sweep of all byte-enable patterns while idle
    for (int be = 0; be < 256; be++) begin
      issue(3'b000, be[7:0], 32'd0, 1'b1, r, o, d, it, r2, ak);
      check("R2 R9 be sweep rdy", {63'd0, r}, {63'd0, be == 8'hEF});
      check("R10 be sweep oe", {63'd0, o}, 64'd0);
      if (be == 8'hEF) begin
        check("R3 intr masked first", {63'd0, it}, 64'd0);
        check("R2 one clock", {63'd0, r2}, 64'd0);
        abort_pair();
        @(negedge clk);
        check("R8 intr back", {63'd0, intr_req}, 64'd1);
        issue(3'b000, 8'hFE, 32'd0, 1'b1, r, o, d, it, r2, ak);
        check("R8 second after abort", {63'd0, r}, 64'd0);
        check("R8 no ack", {63'd0, ak}, 64'd0);
      end
    end

    // R4-R7: full pairs for every vector with varying gaps
    for (int v = 0; v < 256; v++) begin
      irq_vector = v[7:0];
      issue(3'b000, 8'hEF, 32'd0, 1'b1, r, o, d, it, r2, ak);
      check("R2 first rdy", {63'd0, r}, 64'd1);
      check("R3 intr masked", {63'd0, it}, 64'd0);
      irq_vector = ~v[7:0];
      for (int g = 0; g < v % 4; g++) begin
        @(negedge clk);
        check("R5 gap quiet", {62'd0, rdy, intr_req}, 64'd0);
      end
      issue(3'b000, 8'hFE, 32'd0, 1'b1, r, o, d, it, r2, ak);
      check("R4 second rdy", {62'd0, r, o}, 64'd3);
      check("R4 R6 vector", d, {56'd0, v[7:0]});
      check("R7 ack", {63'd0, ak}, 64'd1);
      check("R10 after ready", {62'd0, r2, data_oe}, 64'd0);
      check("R1 intr returns", {63'd0, intr_req}, 64'd1);
      @(negedge clk);
      check("R7 ack single", {63'd0, ack_pulse}, 64'd0);
    end

    // R9: second pattern while idle
    issue(3'b000, 8'hFE, 32'd0, 1'b1, r, o, d, it, r2, ak);
    check("R9 second while idle", {62'd0, r, ak}, 64'd0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule